// File: doc/BRIEF.md
# Coherence Miss Tracker and Message Formatter

This unit sits between a private cache controller and an on-chip network. It keeps a small table of outstanding transactions. Each entry holds a status, a line address and a data word. For each tracked transaction it sends one protocol message on the request class of the network: a read request for a miss, or a write-back that carries the evicted data. The destination of each message is the home node, which is taken from the low bits of the line address.

Replies arrive on a separate reply class of the network. The unit always accepts them, so a reply can never wait behind requests that nobody is consuming. A reply whose address and kind match an entry that has already been sent completes that entry. The completion goes back to the cache in the same cycle and the entry is freed. A reply that matches no entry raises an error flag in that cycle.

A second read miss to a line that already has a read outstanding is merged into the existing entry, and no further message is sent. Replies may arrive in any order.

Top module: `miss_tracker`

## Requirements
- R1: After reset, no request message is offered (`net_req_valid`=0), no completion is given (`cache_rsp_valid`=0), `unmatched_err` is 0 and `cache_req_ready` is 1.
- R2: An accepted read miss that allocates an entry produces a request message in the next cycle, with kind 0 (read request), the same address, and destination equal to the address's low `NODE_W` bits.
- R3: An accepted write-back produces a request message with kind 1 (write-back), the address and the write-back data.
- R4: While `net_req_valid` is 1 and `net_req_ready` is 0, the offered message stays valid and unchanged in the next cycle.
- R5: A read miss whose address matches a live entry that is a read is accepted and merged. No new message is produced for it, and this holds even when the table is full.
- R6: A request is refused (`cache_req_ready`=0) when its address matches a live entry and the two are not both reads. A request to a new address is refused when all `ENTRIES` entries are live. Once a reply has freed an entry, a new address is accepted again.
- R7: A reply on the reply class with `net_rsp_valid`=1 matches an entry when that entry has been sent and has the same address and the same kind (kind 0 = read reply, 1 = write acknowledgement). A matching reply gives `cache_rsp_valid`=1 in the same cycle, with the reply's address and kind. For a read reply the data is the reply data; for a write acknowledgement it is the original write-back data. The entry is then freed.
- R8: `net_rsp_ready` is 1 in every cycle, including cycles in which the request class is stalled.
- R9: A reply with no matching sent entry raises `unmatched_err` for that cycle and gives no completion. A reply whose kind differs from the entry's kind counts as no match.
- R10: Replies may complete entries in any order, regardless of the order in which their requests were sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cache_req_valid | input | 1 | Cache offers a miss or a write-back |
| cache_req_ready | output | 1 | Unit accepts the cache request |
| cache_req_wb | input | 1 | 1 = write-back, 0 = read miss |
| cache_req_addr | input | ADDR_W | Line address |
| cache_req_data | input | DATA_W | Write-back data |
| cache_rsp_valid | output | 1 | Completion to the cache |
| cache_rsp_wb | output | 1 | Completion kind, 1 = write acknowledge |
| cache_rsp_addr | output | ADDR_W | Completed line address |
| cache_rsp_data | output | DATA_W | Read data, or the original write-back data |
| net_req_valid | output | 1 | Request-class message valid |
| net_req_ready | input | 1 | Network takes the request message |
| net_req_wb | output | 1 | Message kind, 0 = read request, 1 = write-back |
| net_req_dest | output | NODE_W | Home node |
| net_req_addr | output | ADDR_W | Message address |
| net_req_data | output | DATA_W | Write-back data |
| net_rsp_valid | input | 1 | Reply-class message valid |
| net_rsp_ready | output | 1 | Reply accepted, always 1 |
| net_rsp_wb | input | 1 | Reply kind, 0 = read reply, 1 = write acknowledge |
| net_rsp_addr | input | ADDR_W | Reply address |
| net_rsp_data | input | DATA_W | Reply data |
| unmatched_err | output | 1 | Reply matched no sent entry |

## Verification
The bench drives inputs one time unit after a rising edge and samples two units later.

Several outputs are combinational and are checked in the same cycle as their stimulus: `cache_req_ready`, the completion, and the error flag. The entry table is registered, so a newly allocated entry appears as a request message one edge after it is accepted, and the bench samples it after that edge. A stalled message must still be present one edge later.

In the random phase the bench keeps its own list of outstanding transactions. From that list it predicts acceptance, and it checks every message at the edge where it is handed over.

// File: rtl/miss_tracker.sv
module miss_tracker #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 4,
  parameter int NODE_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cache_req_valid,
  output logic              cache_req_ready,
  input  logic              cache_req_wb,
  input  logic [ADDR_W-1:0] cache_req_addr,
  input  logic [DATA_W-1:0] cache_req_data,
  output logic              cache_rsp_valid,
  output logic              cache_rsp_wb,
  output logic [ADDR_W-1:0] cache_rsp_addr,
  output logic [DATA_W-1:0] cache_rsp_data,
  output logic              net_req_valid,
  input  logic              net_req_ready,
  output logic              net_req_wb,
  output logic [NODE_W-1:0] net_req_dest,
  output logic [ADDR_W-1:0] net_req_addr,
  output logic [DATA_W-1:0] net_req_data,
  input  logic              net_rsp_valid,
  output logic              net_rsp_ready,
  input  logic              net_rsp_wb,
  input  logic [ADDR_W-1:0] net_rsp_addr,
  input  logic [DATA_W-1:0] net_rsp_data,
  output logic              unmatched_err
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q, wb_q, sent_q;
  logic [ADDR_W-1:0]  addr_q [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic               hold_q;
  logic [IDX_W-1:0]   hold_idx_q;

  logic [ENTRIES-1:0] hit_vec, live, match_vec;
  logic [IDX_W-1:0]   free_idx, pend_idx, hit_idx, sel_idx;
  logic               has_free, has_pend, any_match, merge_ok, accept, alloc, send;

  always_comb begin
    free_idx = '0; pend_idx = '0; hit_idx = '0;
    has_free = 1'b0; has_pend = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      hit_vec[i]   = net_rsp_valid && vld_q[i] && sent_q[i] &&
                     addr_q[i] == net_rsp_addr && wb_q[i] == net_rsp_wb;
      live[i]      = vld_q[i] && !hit_vec[i];
      match_vec[i] = live[i] && addr_q[i] == cache_req_addr;
      if (!live[i]) begin free_idx = IDX_W'(i); has_free = 1'b1; end
      if (vld_q[i] && !sent_q[i]) begin pend_idx = IDX_W'(i); has_pend = 1'b1; end
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign any_match       = |match_vec;
  assign merge_ok        = !cache_req_wb && ((match_vec & wb_q) == '0);
  assign cache_req_ready = any_match ? merge_ok : has_free;
  assign accept          = cache_req_valid && cache_req_ready;
  assign alloc           = accept && !any_match;

  assign sel_idx       = hold_q ? hold_idx_q : pend_idx;
  assign net_req_valid = hold_q || has_pend;
  assign net_req_wb    = wb_q[sel_idx];
  assign net_req_addr  = addr_q[sel_idx];
  assign net_req_dest  = addr_q[sel_idx][NODE_W-1:0];
  assign net_req_data  = data_q[sel_idx];
  assign send          = net_req_valid && net_req_ready;

  assign net_rsp_ready   = 1'b1;
  assign cache_rsp_valid = |hit_vec;
  assign cache_rsp_wb    = net_rsp_wb;
  assign cache_rsp_addr  = net_rsp_addr;
  assign cache_rsp_data  = net_rsp_wb ? data_q[hit_idx] : net_rsp_data;
  assign unmatched_err   = net_rsp_valid && !(|hit_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q      <= '0;
      sent_q     <= '0;
      wb_q       <= '0;
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (hit_vec[i]) vld_q[i] <= 1'b0;
      if (send) sent_q[sel_idx] <= 1'b1;
      if (alloc) begin
        vld_q[free_idx]  <= 1'b1;
        sent_q[free_idx] <= 1'b0;
        wb_q[free_idx]   <= cache_req_wb;
      end
      hold_q     <= net_req_valid && !net_req_ready;
      hold_idx_q <= sel_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      addr_q[free_idx] <= cache_req_addr;
      data_q[free_idx] <= cache_req_data;
    end
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_req_valid && !net_req_ready |=> net_req_valid && $stable(net_req_addr) &&
      $stable(net_req_wb) && $stable(net_req_data));

  // R2
  alloc_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> net_req_valid);

  // R5
  merge_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && any_match && !net_req_valid |=> !net_req_valid);

  // R9
  reply_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_rsp_valid |-> (cache_rsp_valid ^ unmatched_err));
endmodule

// File: tb/miss_tracker_tb_top.sv
module miss_tracker_tb_top;
  localparam int AW = 16, DW = 32, NE = 4, NW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cq_valid = 0, cq_wb = 0, nq_ready = 0, nr_valid = 0, nr_wb = 0;
  logic [AW-1:0] cq_addr = '0, nr_addr = '0;
  logic [DW-1:0] cq_data = '0, nr_data = '0;
  logic cq_ready, cr_valid, cr_wb, nq_valid, nq_wb, nr_ready, err;
  logic [AW-1:0] cr_addr, nq_addr;
  logic [DW-1:0] cr_data, nq_data;
  logic [NW-1:0] nq_dest;

  int n_chk = 0, n_fail = 0;
  bit mv[NE], mwb[NE], ms[NE];
  logic [AW-1:0] ma[NE];
  logic [DW-1:0] md[NE];

  always #5 clk = ~clk;

  miss_tracker #(.ADDR_W(AW), .DATA_W(DW), .ENTRIES(NE), .NODE_W(NW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cache_req_valid(cq_valid), .cache_req_ready(cq_ready), .cache_req_wb(cq_wb),
    .cache_req_addr(cq_addr), .cache_req_data(cq_data),
    .cache_rsp_valid(cr_valid), .cache_rsp_wb(cr_wb), .cache_rsp_addr(cr_addr),
    .cache_rsp_data(cr_data),
    .net_req_valid(nq_valid), .net_req_ready(nq_ready), .net_req_wb(nq_wb),
    .net_req_dest(nq_dest), .net_req_addr(nq_addr), .net_req_data(nq_data),
    .net_rsp_valid(nr_valid), .net_rsp_ready(nr_ready), .net_rsp_wb(nr_wb),
    .net_rsp_addr(nr_addr), .net_rsp_data(nr_data), .unmatched_err(err));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rsp(input bit wb, input logic [AW-1:0] a, input logic [DW-1:0] d);
    nr_valid = 1; nr_wb = wb; nr_addr = a; nr_data = d;
  endtask

  function automatic int find(input logic [AW-1:0] a);
    for (int i = 0; i < NE; i++) if (mv[i] && ma[i] == a) return i;
    return -1;
  endfunction

  function automatic int used();
    int c = 0;
    for (int i = 0; i < NE; i++) if (mv[i]) c++;
    return c;
  endfunction

  task automatic do_reset();
    rst_n = 0; cq_valid = 0; nr_valid = 0; nq_ready = 0;
    step(); step(); rst_n = 1;
  endtask

  initial begin
    #(10 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1ce5));
    do_reset(); #2;
    chk(!nq_valid && !cr_valid && !err, "R1 idle outputs", {nq_valid, cr_valid, err}, 0);
    chk(cq_ready, "R1 ready", cq_ready, 1);

    step(); cq_valid = 1; cq_wb = 0; cq_addr = 16'h0105; #1;
    chk(cq_ready, "R2 accept read", cq_ready, 1);
    step(); cq_valid = 0; #1;
    chk(nq_valid && !nq_wb && nq_addr == 16'h0105 && nq_dest == 2'd1, "R2 read request",
        {nq_valid, nq_wb, nq_dest, nq_addr}, {1'b1, 1'b0, 2'd1, 16'h0105});
    cq_valid = 1; cq_wb = 0; cq_addr = 16'h0105; #1;
    chk(cq_ready, "R5 merge accepted", cq_ready, 1);
    step(); cq_wb = 1; cq_addr = 16'h0206; cq_data = 32'hAAAA5555; #1;
    chk(nq_valid && nq_addr == 16'h0105, "R4 stalled message held", nq_addr, 16'h0105);
    chk(cq_ready, "R3 accept write-back", cq_ready, 1);
    step(); cq_valid = 0; nq_ready = 1;
    step(); #1;
    chk(nq_valid && nq_wb && nq_addr == 16'h0206 && nq_data == 32'hAAAA5555 && nq_dest == 2'd2,
        "R3 write-back message", {nq_wb, nq_addr, nq_data}, {1'b1, 16'h0206, 32'hAAAA5555});
    step(); #1;
    chk(!nq_valid, "R5 merge sent nothing", nq_valid, 0);
    cq_valid = 0; cq_wb = 0; cq_addr = 16'h0206; #1;
    chk(!cq_ready, "R6 read conflicts with write-back", cq_ready, 0);
    cq_valid = 1; cq_addr = 16'h0300;
    step(); cq_addr = 16'h0401;
    step(); cq_valid = 0; cq_addr = 16'h0502;
    step(); step(); step(); #1;
    chk(!cq_ready, "R6 full refuses new address", cq_ready, 0);
    cq_addr = 16'h0105; #1;
    chk(cq_ready, "R5 merge while full", cq_ready, 1);

    nq_ready = 0;
    rsp(1, 16'h0206, 32'h0); #1;
    chk(cr_valid && cr_wb && cr_addr == 16'h0206 && cr_data == 32'hAAAA5555 && !err,
        "R7 write ack returns original data", cr_data, 32'hAAAA5555);
    chk(nr_ready, "R8 reply accepted while request class stalled", nr_ready, 1);
    step(); rsp(0, 16'h0401, 32'h12345678); #1;
    chk(cr_valid && !cr_wb && cr_addr == 16'h0401 && cr_data == 32'h12345678,
        "R10 out of order read reply", cr_data, 32'h12345678);
    step(); rsp(0, 16'h0206, 32'h1); #1;
    chk(err && !cr_valid, "R9 reply to freed entry", {err, cr_valid}, 2'b10);
    step(); rsp(1, 16'h0105, 32'h1); #1;
    chk(err && !cr_valid, "R9 kind mismatch", {err, cr_valid}, 2'b10);
    step(); nr_valid = 0; cq_addr = 16'h0502; #1;
    chk(cq_ready, "R6 freed entry reusable", cq_ready, 1);
    rsp(0, 16'h0300, 32'h77); #1;
    chk(cr_valid && cr_data == 32'h77, "R10 reply third request", cr_data, 32'h77);
    step(); nr_valid = 0;

    do_reset();
    for (int i = 0; i < NE; i++) mv[i] = 0;
    begin
      bit prev_stall = 0;
      logic [AW-1:0] prev_addr = '0;
      for (int it = 0; it < 4000; it++) begin
        int act, f, k;
        bit exp_rdy;
        step();
        cq_valid = 0; nr_valid = 0;
        nq_ready = ($urandom % 4) != 0;
        act = $urandom % 4;
        if (act == 1) begin
          cq_wb = $urandom % 3 == 0; cq_addr = 16'(($urandom % 8) * 5);
          cq_data = $urandom; cq_valid = 1;
        end else if (act == 2) begin
          k = -1;
          for (int j = 0; j < NE; j++) if (mv[j] && ms[j] && (k < 0 || $urandom % 2 == 0)) k = j;
          if (k >= 0) rsp(mwb[k], ma[k], $urandom);
          else act = 0;
        end else if (act == 3) begin
          rsp($urandom % 2, 16'h8000 | 16'($urandom % 256), $urandom);
        end
        #1;
        if (prev_stall)
          chk(nq_valid && nq_addr == prev_addr, "R4 random hold", nq_addr, prev_addr);
        if (act == 1) begin
          f = find(cq_addr);
          exp_rdy = (f >= 0) ? (!mwb[f] && !cq_wb) : (used() < NE);
          chk(cq_ready == exp_rdy, (f >= 0) ? "R5 R6 random match" : "R6 random capacity",
              cq_ready, exp_rdy);
        end
        if (act == 2) begin
          f = find(nr_addr);
          chk(cr_valid && !err && cr_wb == mwb[f] && cr_addr == ma[f] &&
              cr_data == (mwb[f] ? md[f] : nr_data), "R7 R10 random completion",
              cr_data, mwb[f] ? md[f] : nr_data);
          mv[f] = 0;
        end
        if (act == 3) chk(err && !cr_valid, "R9 random stray reply", {err, cr_valid}, 2'b10);
        if (nq_valid && nq_ready) begin
          f = find(nq_addr);
          chk(f >= 0 && !ms[f] && nq_wb == mwb[f] && nq_dest == nq_addr[NW-1:0] &&
              (!mwb[f] || nq_data == md[f]), nq_wb ? "R3 random message" : "R2 random message",
              {nq_wb, nq_addr}, (f >= 0) ? {mwb[f], ma[f]} : 0);
          if (f >= 0) ms[f] = 1;
        end
        if (act == 1 && cq_ready && find(cq_addr) < 0) begin
          for (int j = 0; j < NE; j++)
            if (!mv[j]) begin
              mv[j] = 1; ms[j] = 0; mwb[j] = cq_wb; ma[j] = cq_addr; md[j] = cq_data;
              break;
            end
        end
        prev_stall = nq_valid && !nq_ready;
        prev_addr = nq_addr;
      end
    end
    step(); cq_valid = 0; nr_valid = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule